// File: doc/BRIEF.md
# Processor Reset Initialization Sequencer

This block carries out the architectural register set-up that follows a processor reset exception. A one-cycle request starts it. At that moment it latches the current status word, the initial stack pointer and the initial program counter, which come from reset vectors 0 and 1, and it latches the processor model level. It then steps through a fixed series of register writes, one per cycle. Each write has its own write strobe, and the data for that write is shown on a matching output bus. When all writes are committed, the block raises `done_o` for one cycle.

Every model first releases the stopped state. It then rewrites the status word, zeroes the vector base, loads the supervisor stack pointer and finally loads the program counter. Model levels 2 and 3 also clear the cache control and cache address registers, and this write comes just before the program counter write. Models 0 and 1 run the same series without the cache write. A model code outside the supported range produces no writes and only finishes.

The request and the strobes are plain control pins. They have no handshake, because every write is a single-cycle commit into the register file next to the block.

Top module: `rst_init_seq`

## Requirements
- R1: While reset is applied and in the first cycle after it, every write strobe and `done_o` are low.
- R2: For a supported model (0 to 3), `stop_clr_o` is high in the first cycle after the edge that accepted the request.
- R3: With `sr_we_o` high, `sr_o` equals the latched status word ANDed with 0x271F and then ORed with 0x2700. This gives bit 13 (supervisor) = 1, bits 10:8 (interrupt level) = 7, and bits 15, 14 and 12 (trace and master) = 0.
- R4: With `vbr_we_o` high, `vbr_o` is zero.
- R5: `ssp_o` and `pc_o` carry the stack pointer and program counter values latched on the accepting edge, even if the inputs change later.
- R6: Models 2 and 3 pulse `cache_we_o` exactly once, with `cacr_o` and `caar_o` both zero. Models 0 and 1 never pulse it.
- R7: The write order is: stop clear, status, vector base, stack pointer, (cache), program counter. `done_o` rises in cycle 6 after acceptance for models 0 and 1, and in cycle 7 for models 2 and 3.
- R8: A model code of 4 to 7 gives no strobe at all, and `done_o` is high in cycle 1 after acceptance.
- R9: `done_o` lasts exactly one cycle. A request seen before `done_o` has been shown is ignored.
- R10: At most one write strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Reset-exception request, sampled when idle |
| model_i | input | MODEL_W (3) | Processor model level |
| sr_i | input | SR_W (16) | Current status word |
| init_sp_i | input | AW (32) | Initial stack pointer (vector 0) |
| init_pc_i | input | AW (32) | Initial program counter (vector 1) |
| stop_clr_o | output | 1 | Release the stopped state |
| sr_we_o | output | 1 | Status word write strobe |
| sr_o | output | SR_W (16) | New status word |
| vbr_we_o | output | 1 | Vector base write strobe |
| vbr_o | output | AW (32) | New vector base |
| ssp_we_o | output | 1 | Supervisor stack pointer write strobe |
| ssp_o | output | AW (32) | New supervisor stack pointer |
| cache_we_o | output | 1 | Cache control/address write strobe |
| cacr_o | output | CW (32) | New cache control value |
| caar_o | output | AW (32) | New cache address value |
| pc_we_o | output | 1 | Program counter write strobe |
| pc_o | output | AW (32) | New program counter |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default parameters: a 3-bit model code with four supported levels and the cache write from level 2 upward. The 3-bit model code makes the unsupported codes 4 to 7 reachable, so the no-write path can be exercised next to both the short series and the long series. The 32-bit vector widths allow stack and program counter patterns with every byte different. These patterns are flipped after acceptance, which shows that the block reads only its latched copies.

// File: rtl/rst_init_pkg.sv
package rst_init_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STOP,
    ST_SR,
    ST_VBR,
    ST_SSP,
    ST_CACHE,
    ST_PC,
    ST_DONE
  } seq_state_e;

  localparam int SR_W = 16;
  localparam logic [SR_W-1:0] SR_KEEP_MASK = 16'h271F;
  localparam logic [SR_W-1:0] SR_FORCE_SET = 16'h2700;

  function automatic logic [SR_W-1:0] sr_on_reset(input logic [SR_W-1:0] cur);
    return (cur & SR_KEEP_MASK) | SR_FORCE_SET;
  endfunction

endpackage

// File: rtl/rst_init_decode.sv
module rst_init_decode #(
  parameter int MODEL_W    = 3,
  parameter int NUM_MODELS = 4,
  parameter int CACHE_MIN  = 2
) (
  input  logic [MODEL_W-1:0] model_i,
  output logic               known_o,
  output logic               has_cache_o
);

  localparam int CODE_SPAN = 1 << MODEL_W;

  generate
    if (NUM_MODELS >= CODE_SPAN) begin : g_all_known
      assign known_o = 1'b1;
    end else begin : g_range
      assign known_o = (model_i < MODEL_W'(NUM_MODELS));
    end
  endgenerate

  assign has_cache_o = known_o && (model_i >= MODEL_W'(CACHE_MIN));

endmodule

// File: rtl/rst_init_fsm.sv
module rst_init_fsm
  import rst_init_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic       known_i,
  input  logic       has_cache_i,
  output seq_state_e state_o,
  output logic       accept_o
);

  seq_state_e state_q, state_d;
  logic       cache_q;

  assign accept_o = (state_q == ST_IDLE) && req_i;
  assign state_o  = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_i) state_d = known_i ? ST_STOP : ST_DONE;
      ST_STOP:  state_d = ST_SR;
      ST_SR:    state_d = ST_VBR;
      ST_VBR:   state_d = ST_SSP;
      ST_SSP:   state_d = cache_q ? ST_CACHE : ST_PC;
      ST_CACHE: state_d = ST_PC;
      ST_PC:    state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cache_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_o) cache_q <= has_cache_i;
    end
  end

endmodule

// File: rtl/rst_init_seq.sv
module rst_init_seq
  import rst_init_pkg::*;
#(
  parameter int MODEL_W    = 3,
  parameter int NUM_MODELS = 4,
  parameter int CACHE_MIN  = 2,
  parameter int AW         = 32,
  parameter int CW         = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_i,
  input  logic [MODEL_W-1:0] model_i,
  input  logic [SR_W-1:0]    sr_i,
  input  logic [AW-1:0]      init_sp_i,
  input  logic [AW-1:0]      init_pc_i,
  output logic               stop_clr_o,
  output logic               sr_we_o,
  output logic [SR_W-1:0]    sr_o,
  output logic               vbr_we_o,
  output logic [AW-1:0]      vbr_o,
  output logic               ssp_we_o,
  output logic [AW-1:0]      ssp_o,
  output logic               cache_we_o,
  output logic [CW-1:0]      cacr_o,
  output logic [AW-1:0]      caar_o,
  output logic               pc_we_o,
  output logic [AW-1:0]      pc_o,
  output logic               done_o
);

  logic            known, has_cache, accept;
  seq_state_e      state;
  logic [SR_W-1:0] sr_q;
  logic [AW-1:0]   sp_q, pc_q;

  rst_init_decode #(
    .MODEL_W   (MODEL_W),
    .NUM_MODELS(NUM_MODELS),
    .CACHE_MIN (CACHE_MIN)
  ) u_decode (
    .model_i    (model_i),
    .known_o    (known),
    .has_cache_o(has_cache)
  );

  rst_init_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .known_i    (known),
    .has_cache_i(has_cache),
    .state_o    (state),
    .accept_o   (accept)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      sp_q <= '0;
      pc_q <= '0;
    end else if (accept) begin
      sr_q <= sr_i;
      sp_q <= init_sp_i;
      pc_q <= init_pc_i;
    end
  end

  assign stop_clr_o = (state == ST_STOP);
  assign sr_we_o    = (state == ST_SR);
  assign vbr_we_o   = (state == ST_VBR);
  assign ssp_we_o   = (state == ST_SSP);
  assign cache_we_o = (state == ST_CACHE);
  assign pc_we_o    = (state == ST_PC);
  assign done_o     = (state == ST_DONE);

  assign sr_o   = sr_on_reset(sr_q);
  assign vbr_o  = '0;
  assign ssp_o  = sp_q;
  assign pc_o   = pc_q;
  assign cacr_o = '0;
  assign caar_o = '0;

endmodule

// File: rtl/rst_init_chk.sv
module rst_init_chk #(
  parameter int SR_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            stop_clr_o,
  input logic            sr_we_o,
  input logic [SR_W-1:0] sr_o,
  input logic            vbr_we_o,
  input logic            ssp_we_o,
  input logic            cache_we_o,
  input logic            pc_we_o,
  input logic            done_o
);

  AST_SR_SUPERVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    sr_we_o |-> (sr_o[13] && sr_o[10:8] == 3'b111 && sr_o[15:14] == 2'b00 && !sr_o[12])); // R3

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stop_clr_o, sr_we_o, vbr_we_o, ssp_we_o, cache_we_o, pc_we_o})); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9

  AST_SR_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    sr_we_o |-> $past(stop_clr_o)); // R2

  AST_VBR_AFTER_SR: assert property (@(posedge clk) disable iff (!rst_n)
    vbr_we_o |-> $past(sr_we_o)); // R7

endmodule

bind rst_init_seq rst_init_chk #(.SR_W(rst_init_pkg::SR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stop_clr_o(stop_clr_o),
  .sr_we_o   (sr_we_o),
  .sr_o      (sr_o),
  .vbr_we_o  (vbr_we_o),
  .ssp_we_o  (ssp_we_o),
  .cache_we_o(cache_we_o),
  .pc_we_o   (pc_we_o),
  .done_o    (done_o)
);

// File: tb/sim_rst_init_seq.sv
module sim_rst_init_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [2:0]  model = '0;
  logic [15:0] sr_in = '0;
  logic [31:0] sp_in = '0, pc_in = '0;
  logic        stop_clr, sr_we, vbr_we, ssp_we, cache_we, pc_we, done;
  logic [15:0] sr_out;
  logic [31:0] vbr_out, ssp_out, caar_out, pc_out, cacr_out;

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rst_init_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .model_i(model), .sr_i(sr_in),
    .init_sp_i(sp_in), .init_pc_i(pc_in), .stop_clr_o(stop_clr),
    .sr_we_o(sr_we), .sr_o(sr_out), .vbr_we_o(vbr_we), .vbr_o(vbr_out),
    .ssp_we_o(ssp_we), .ssp_o(ssp_out), .cache_we_o(cache_we),
    .cacr_o(cacr_out), .caar_o(caar_out), .pc_we_o(pc_we), .pc_o(pc_out),
    .done_o(done)
  );

  // model, status in, sp, pc, expected status, cache expected, done cycle
  localparam int NV = 6;
  localparam logic [2:0]  V_MODEL [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd5, 3'd7};
  localparam logic [15:0] V_SR    [NV] = '{16'hFFFF, 16'h0000, 16'hA5C3, 16'h8010, 16'h1234, 16'hFFFF};
  localparam logic [31:0] V_SP    [NV] = '{32'h0001_0000, 32'h1234_5678, 32'hCAFE_0100, 32'h0000_8000, 32'h5, 32'h6};
  localparam logic [31:0] V_PC    [NV] = '{32'h00F8_0000, 32'h89AB_CDEF, 32'h0040_0020, 32'hFFFF_FFFE, 32'h7, 32'h8};
  localparam logic [15:0] V_ESR   [NV] = '{16'h271F, 16'h2700, 16'h2703, 16'h2710, 16'h0, 16'h0};
  localparam bit          V_CACHE [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam int          V_LAT   [NV] = '{6, 6, 7, 7, 1, 1};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_seq(input logic [2:0] m, input logic [15:0] s, input logic [31:0] sp,
                         input logic [31:0] pc, input logic [15:0] esr, input bit ecache,
                         input int elat, input bit poke_busy);
    int done_at = 0, done_cnt = 0, stop_at = 0, pc_at = 0, cache_cnt = 0, strobe_cnt = 0, multi = 0;
    logic [15:0] sr_seen = '0;
    logic [31:0] ssp_seen = '0, pc_seen = '0, vbr_seen = 32'hDEAD, cache_seen = 32'hDEAD;
    @(negedge clk);
    model = m; sr_in = s; sp_in = sp; pc_in = pc; req = 1'b1;
    @(negedge clk);
    req = 1'b0; model = 3'd2; sr_in = ~s; sp_in = ~sp; pc_in = ~pc;
    for (int i = 1; i <= 10; i++) begin
      int n;
      n = int'(stop_clr) + int'(sr_we) + int'(vbr_we) + int'(ssp_we) + int'(cache_we) + int'(pc_we);
      strobe_cnt += n;
      if (n > 1) multi++;
      if (stop_clr && stop_at == 0) stop_at = i;
      if (sr_we) sr_seen = sr_out;
      if (vbr_we) vbr_seen = vbr_out;
      if (ssp_we) ssp_seen = ssp_out;
      if (cache_we) begin cache_cnt++; cache_seen = cacr_out | caar_out; end
      if (pc_we) begin pc_at = i; pc_seen = pc_out; end
      if (done) begin done_cnt++; if (done_at == 0) done_at = i; end
      if (poke_busy) req = (i == 2 || i == 3);
      @(negedge clk);
    end
    req = 1'b0;
    chk(done_at == elat, "R7/R8 done cycle", 32'(done_at), 32'(elat));
    chk(done_cnt == 1, "R9 single done", 32'(done_cnt), 32'd1);
    chk(multi == 0, "R10 strobe overlap", 32'(multi), 32'd0);
    if (elat == 1) begin
      chk(strobe_cnt == 0, "R8 no writes", 32'(strobe_cnt), 32'd0);
    end else begin
      chk(stop_at == 1, "R2 stop clear first", 32'(stop_at), 32'd1);
      chk(sr_seen == esr, "R3 status word", 32'(sr_seen), 32'(esr));
      chk(vbr_seen == 32'd0, "R4 vector base", vbr_seen, 32'd0);
      chk(ssp_seen == sp, "R5 stack pointer", ssp_seen, sp);
      chk(pc_seen == pc, "R5 program counter", pc_seen, pc);
      chk(pc_at == elat - 1, "R7 pc last write", 32'(pc_at), 32'(elat - 1));
      chk(cache_cnt == int'(ecache), "R6 cache write count", 32'(cache_cnt), 32'(ecache));
      if (ecache) chk(cache_seen == 32'd0, "R6 cache zero", cache_seen, 32'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({stop_clr, sr_we, vbr_we, ssp_we, cache_we, pc_we, done} == 7'd0, "R1 in reset",
        32'({stop_clr, sr_we, vbr_we, ssp_we, cache_we, pc_we, done}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({stop_clr, sr_we, vbr_we, ssp_we, cache_we, pc_we, done} == 7'd0, "R1 after reset",
        32'({stop_clr, sr_we, vbr_we, ssp_we, cache_we, pc_we, done}), 32'd0);
    for (int v = 0; v < NV; v++)
      run_seq(V_MODEL[v], V_SR[v], V_SP[v], V_PC[v], V_ESR[v], V_CACHE[v], V_LAT[v], 1'b0);
    // R9: requests raised mid-sequence are ignored
    run_seq(3'd0, 16'h00FF, 32'h0000_1000, 32'h0000_2000, 16'h271F, 1'b0, 6, 1'b1);
    // R8: unsupported code directly followed by a supported one
    run_seq(3'd4, 16'h0, 32'h1, 32'h2, 16'h0, 1'b0, 1, 1'b0);
    run_seq(3'd3, 16'h0000, 32'hA0A0_A0A0, 32'h0505_0505, 16'h2700, 1'b1, 7, 1'b0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule